// File: doc/BRIEF.md
# E1 Frame Alignment Monitor

This block watches a 2.048 Mb/s E1 serial stream with 32 timeslots per frame and finds the frame boundary. It takes one bit on every rising edge of the block clock, which is the receive bit clock. It searches bit by bit for the seven-bit alignment word that every second frame carries in timeslot zero. The frames in between carry a service word in the same timeslot, and the block uses it to confirm the boundary. After a fixed three-step confirmation it declares lock and reports the position of every incoming bit as a timeslot number and a bit number.

While locked, the block marks the last bit of every frame that comes before an alignment-word frame with a one-cycle sync pulse. It raises a one-cycle fault pulse for each alignment word that arrives with errors, and it drops lock after a run of errored words. While it is not locked, it never raises sync and it raises fault at a fixed rate of one pulse every two frames. Downstream logic uses the counters and the sync pulse to line up timeslot extraction, and uses the fault pulse to count alignment errors.

Top module: `e1fa_monitor`

## Requirements
- R1: While rst_n is low, locked, sync_pulse and fault_pulse are 0 and bit_cnt and ts_cnt are 0.
- R2: The pair {ts_cnt, bit_cnt} is a frame position from 0 to 255 that steps by one on every clock. After 255 it returns to 0. Position 0 is the first bit received in timeslot zero. While locked, the pair never skips or repeats a value.
- R3: The alignment word is 0011011, first-received bit first, and sits at frame positions 1 to 7. While searching, a match on the last seven received bits moves the next reported position to 8 (ts_cnt 1, bit_cnt 0).
- R4: Lock is declared only after three words, one frame apart: an alignment word, then a service word whose bit at frame position 1 is 1, then an alignment word. locked rises in the cycle after the last bit of the third word, with the counters then showing position 8. If either confirming word fails, the search resumes with the very next bit.
- R5: While locked, sync_pulse is high for exactly one cycle, at position 255 of a frame that is followed by an alignment-word frame. It is therefore high once every 512 cycles.
- R6: While locked, an alignment word that differs from 0011011 in any bit causes fault_pulse to be high for exactly one cycle, in the cycle after that word's last bit. The service word in the frames between is not checked.
- R7: Lock is lost on the third errored alignment word in a row, and locked falls in the same cycle as that word's fault pulse. A correct alignment word clears the run of errors.
- R8: While not locked, sync_pulse stays 0 and fault_pulse is high for one cycle every 512 cycles. The first of these pulses comes 512 cycles after reset is released or after lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial line data, sampled on the rising clock edge |
| sync_pulse | output | 1 | One-cycle marker at the end of the frame before an alignment-word frame |
| fault_pulse | output | 1 | One-cycle alarm: an errored alignment word, or the periodic pulse while unlocked |
| bit_cnt | output | 3 | Bit number inside the current timeslot |
| ts_cnt | output | 5 | Current timeslot number |
| locked | output | 1 | High while frame alignment is held |

## Verification
Two functions can land in the same cycle: the periodic fault pulse while unlocked, and the declaration of lock. After a loss of lock, the stream is set up so that the search restarts on the next alignment word. The confirming word then completes exactly 1024 cycles after the loss, which is where the second periodic fault falls. The bench requires locked and fault_pulse to be high together in that one cycle, with the counters at position 8, and requires fault to be low again one cycle later. It also judges the errored-word fault and the fall of locked, which arrive together on the third bad word in a row.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

  // Alignment search and lock states
  typedef enum logic [1:0] {
    FA_SEARCH    = 2'd0,
    FA_WAIT_SVC  = 2'd1,
    FA_WAIT_WORD = 2'd2,
    FA_LOCKED    = 2'd3
  } fa_state_t;

  function automatic logic fa_is_locked(input fa_state_t s);
    return s == FA_LOCKED;
  endfunction

endpackage

// File: rtl/e1fa_window.sv
// Sliding window over the most recent WORD_W received bits; the oldest bit is the MSB.
module e1fa_window #(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  output logic [WORD_W-1:0] win
);

  logic [WORD_W-2:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[WORD_W-3:0], din};
  end

  assign win = {hist, din};

endmodule

// File: rtl/e1fa_position.sv
// Frame bit position counter with realignment load.
module e1fa_position #(
  parameter int FRAME_BITS = 256,
  parameter int PW         = 8,
  parameter int CHECK_POS  = 7,
  parameter int LOAD_POS   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          realign,
  output logic [PW-1:0] pos,
  output logic          at_check,
  output logic          at_last
);

  localparam logic [PW-1:0] LAST_V  = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] CHECK_V = PW'(CHECK_POS);
  localparam logic [PW-1:0] LOAD_V  = PW'(LOAD_POS);

  function automatic logic [PW-1:0] pos_advance(input logic [PW-1:0] p);
    if (p == LAST_V) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (realign) pos <= LOAD_V;
    else              pos <= pos_advance(pos);
  end

  assign at_check = (pos == CHECK_V);
  assign at_last  = (pos == LAST_V);

endmodule

// File: rtl/e1fa_lock_ctrl.sv
// Search, confirmation and loss-of-lock state machine.
module e1fa_lock_ctrl
  import e1fa_pkg::*;
#(
  parameter int              WORD_W     = 7,
  parameter logic [WORD_W-1:0] FAS_WORD = 7'b0011011,
  parameter int              LOSS_COUNT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] win,
  input  logic              at_check,
  input  logic              at_last,
  output fa_state_t         state,
  output logic              frame_fas,
  output logic              realign,
  output logic              word_err_evt,
  output logic              lock_evt,
  output logic              loss_evt
);

  localparam int EW = $clog2(LOSS_COUNT + 1);
  localparam logic [EW-1:0] ERR_LAST = EW'(LOSS_COUNT - 1);

  function automatic logic word_ok(input logic [WORD_W-1:0] w);
    return w == FAS_WORD;
  endfunction

  // Service word: its first bit (oldest in window) is a one
  function automatic logic svc_ok(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction

  fa_state_t      state_n;
  logic [EW-1:0]  err_cnt;
  logic           word_check;

  assign word_check = fa_is_locked(state) && at_check && frame_fas;

  always_comb begin
    state_n      = state;
    realign      = 1'b0;
    lock_evt     = 1'b0;
    loss_evt     = 1'b0;
    word_err_evt = 1'b0;
    unique case (state)
      FA_SEARCH: begin
        if (word_ok(win)) begin
          realign = 1'b1;
          state_n = FA_WAIT_SVC;
        end
      end
      FA_WAIT_SVC: begin
        if (at_check) state_n = svc_ok(win) ? FA_WAIT_WORD : FA_SEARCH;
      end
      FA_WAIT_WORD: begin
        if (at_check) begin
          if (word_ok(win)) begin
            state_n  = FA_LOCKED;
            lock_evt = 1'b1;
          end else begin
            state_n = FA_SEARCH;
          end
        end
      end
      FA_LOCKED: begin
        if (word_check && !word_ok(win)) begin
          word_err_evt = 1'b1;
          if (err_cnt == ERR_LAST) begin
            loss_evt = 1'b1;
            state_n  = FA_SEARCH;
          end
        end
      end
      default: state_n = FA_SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FA_SEARCH;
      frame_fas <= 1'b0;
      err_cnt   <= '0;
    end else begin
      state <= state_n;
      if (lock_evt)                           frame_fas <= 1'b1;
      else if (fa_is_locked(state) && at_last) frame_fas <= ~frame_fas;
      if (lock_evt || loss_evt)               err_cnt <= '0;
      else if (word_check)                    err_cnt <= word_err_evt ? err_cnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/e1fa_pulses.sv
// Sync and fault pulse generation, including the unlocked periodic fault.
module e1fa_pulses
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  fa_state_t state,
  input  logic      at_last,
  input  logic      frame_fas,
  input  logic      word_err_evt,
  output logic      sync_pulse,
  output logic      fault_pulse,
  output logic      idle_tick
);

  localparam int IDLE_PERIOD = 2 * FRAME_BITS;
  localparam int IW = $clog2(IDLE_PERIOD);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_PERIOD - 1);

  logic [IW-1:0] idle_cnt;
  logic          in_lock;

  assign in_lock    = fa_is_locked(state);
  assign idle_tick  = !in_lock && (idle_cnt == IDLE_LAST);
  assign sync_pulse = in_lock && at_last && !frame_fas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt    <= '0;
      fault_pulse <= 1'b0;
    end else begin
      idle_cnt    <= in_lock ? '0 : idle_cnt + 1'b1;
      fault_pulse <= word_err_evt || idle_tick;
    end
  end

endmodule

// File: rtl/e1fa_monitor.sv
// E1 frame alignment monitor, top level.
module e1fa_monitor
  import e1fa_pkg::*;
#(
  parameter int                BITS_PER_SLOT   = 8,
  parameter int                SLOTS_PER_FRAME = 32,
  parameter int                WORD_W          = 7,
  parameter logic [WORD_W-1:0] FAS_WORD        = 7'b0011011,
  parameter int                LOSS_COUNT      = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rx_bit,
  output logic                                 sync_pulse,
  output logic                                 fault_pulse,
  output logic [$clog2(BITS_PER_SLOT)-1:0]     bit_cnt,
  output logic [$clog2(SLOTS_PER_FRAME)-1:0]   ts_cnt,
  output logic                                 locked
);

  localparam int FRAME_BITS = BITS_PER_SLOT * SLOTS_PER_FRAME;
  localparam int BW         = $clog2(BITS_PER_SLOT);
  localparam int TW         = $clog2(SLOTS_PER_FRAME);
  localparam int PW         = BW + TW;
  localparam int CHECK_POS  = WORD_W;
  localparam int LOAD_POS   = WORD_W + 1;

  logic [WORD_W-1:0] win;
  logic [PW-1:0]     pos;
  logic              at_check, at_last, realign, frame_fas;
  logic              word_err_evt, lock_evt, loss_evt, idle_tick;
  fa_state_t         state;

  e1fa_window #(.WORD_W(WORD_W)) u_win (
    .clk(clk), .rst_n(rst_n), .din(rx_bit), .win(win)
  );

  e1fa_position #(
    .FRAME_BITS(FRAME_BITS), .PW(PW), .CHECK_POS(CHECK_POS), .LOAD_POS(LOAD_POS)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .realign(realign),
    .pos(pos), .at_check(at_check), .at_last(at_last)
  );

  e1fa_lock_ctrl #(
    .WORD_W(WORD_W), .FAS_WORD(FAS_WORD), .LOSS_COUNT(LOSS_COUNT)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .win(win), .at_check(at_check), .at_last(at_last),
    .state(state), .frame_fas(frame_fas), .realign(realign),
    .word_err_evt(word_err_evt), .lock_evt(lock_evt), .loss_evt(loss_evt)
  );

  e1fa_pulses #(.FRAME_BITS(FRAME_BITS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .state(state), .at_last(at_last),
    .frame_fas(frame_fas), .word_err_evt(word_err_evt),
    .sync_pulse(sync_pulse), .fault_pulse(fault_pulse), .idle_tick(idle_tick)
  );

  assign bit_cnt = pos[BW-1:0];
  assign ts_cnt  = pos[PW-1:BW];
  assign locked  = fa_is_locked(state);

endmodule

// File: rtl/e1fa_monitor_sva.sv
module e1fa_monitor_sva #(
  parameter int BW       = 3,
  parameter int TW       = 5,
  parameter int LOAD_POS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_pulse,
  input logic          fault_pulse,
  input logic [BW-1:0] bit_cnt,
  input logic [TW-1:0] ts_cnt,
  input logic          locked,
  input logic          word_err_evt,
  input logic          lock_evt,
  input logic          loss_evt,
  input logic          idle_tick
);

  localparam int PW = BW + TW;
  logic [PW-1:0] posv;
  assign posv = {ts_cnt, bit_cnt};

  AST_SYNC_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> (locked && (&bit_cnt) && (&ts_cnt))); // R5
  AST_SYNC_SILENT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sync_pulse); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> (posv == PW'($past(posv) + 1'b1))); // R2
  AST_LOCK_REALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> (locked && posv == PW'(LOAD_POS))); // R4
  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse); // R6
  AST_ERR_RAISES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    word_err_evt |=> fault_pulse); // R6
  AST_LOSS_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> fault_pulse); // R7
  AST_LOSS_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> !locked); // R7
  AST_IDLE_TICK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    idle_tick |=> fault_pulse); // R8

endmodule

bind e1fa_monitor e1fa_monitor_sva #(.BW(BW), .TW(TW), .LOAD_POS(LOAD_POS)) u_sva (
  .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .fault_pulse(fault_pulse),
  .bit_cnt(bit_cnt), .ts_cnt(ts_cnt), .locked(locked),
  .word_err_evt(word_err_evt), .lock_evt(lock_evt), .loss_evt(loss_evt),
  .idle_tick(idle_tick)
);

// File: tb/sim_e1fa_monitor.sv
module sim_e1fa_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b1;
  logic       sync_pulse, fault_pulse, locked;
  logic [2:0] bit_cnt;
  logic [4:0] ts_cnt;

  always #10 clk = ~clk;

  e1fa_monitor u0 (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sync_pulse(sync_pulse),
    .fault_pulse(fault_pulse), .bit_cnt(bit_cnt), .ts_cnt(ts_cnt), .locked(locked)
  );

  localparam int OFF  = 77;
  localparam int KEND = 44 * 256 - OFF;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  int m_mode;   // 0 search, 1 expect service, 2 expect word, 3 locked
  int m_pos;
  int m_err;
  int m_idle;
  bit m_fas;
  bit m_fault;
  bit hq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int kidx(input int fn, input int p);
    return fn * 256 + p - OFF;
  endfunction

  function automatic bit errored_frame(input int fn);
    return fn inside {10, 16, 22, 24, 26, 34, 36, 40};
  endfunction

  function automatic bit stream_bit(input int k);
    int p, fn;
    bit [6:0] fasw, svcw;
    fasw = 7'b0011011;
    svcw = 7'b1011111;
    p  = (k + OFF) % 256;
    fn = (k + OFF) / 256;
    if (p >= 1 && p <= 7) begin
      if (fn % 2 == 0) begin
        if (errored_frame(fn) && p == 3) return ~fasw[7 - p];
        return fasw[7 - p];
      end
      return svcw[7 - p];
    end
    return 1'b1;
  endfunction

  task automatic model_step(input bit b);
    bit word_hit, svc_hit, nf;
    string pat;
    pat = "0011011";
    hq.push_back(b);
    while (hq.size() > 7) void'(hq.pop_front());
    word_hit = 1'b1;
    foreach (hq[i]) if (hq[i] != (pat[i] == "1")) word_hit = 1'b0;
    svc_hit = hq[0];
    nf = (m_mode == 3 && m_fas && m_pos == 7 && !word_hit) || (m_mode != 3 && m_idle == 511);
    m_idle = (m_mode == 3) ? 0 : (m_idle + 1) % 512;
    if (m_mode == 0) begin
      if (word_hit) begin m_mode = 1; m_pos = 8; end
      else m_pos = (m_pos + 1) % 256;
    end else begin
      if (m_pos == 7) begin
        if (m_mode == 1) m_mode = svc_hit ? 2 : 0;
        else if (m_mode == 2) begin
          if (word_hit) begin m_mode = 3; m_fas = 1'b1; m_err = 0; end
          else m_mode = 0;
        end else if (m_fas) begin
          if (word_hit) m_err = 0;
          else begin
            m_err++;
            if (m_err == 3) begin m_mode = 0; m_err = 0; end
          end
        end
      end
      if (m_mode == 3 && m_pos == 255) m_fas = ~m_fas;
      m_pos = (m_pos + 1) % 256;
    end
    m_fault = nf;
  endtask

  task automatic compare_model();
    bit es;
    es = (m_mode == 3) && (m_pos == 255) && !m_fas;
    chk(locked == (m_mode == 3), "MODEL R4 locked", int'(locked), int'(m_mode == 3));
    chk(sync_pulse == es, "MODEL R5 sync", int'(sync_pulse), int'(es));
    chk(fault_pulse == m_fault, "MODEL R6 fault", int'(fault_pulse), int'(m_fault));
    chk(int'({ts_cnt, bit_cnt}) == m_pos, "MODEL R2 position", int'({ts_cnt, bit_cnt}), m_pos);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int early_faults = 0;
    int sync_unlocked = 0;
    m_mode = 0; m_pos = 0; m_err = 0; m_idle = 0; m_fas = 1'b0; m_fault = 1'b0;
    for (int i = 0; i < 6; i++) hq.push_back(1'b0);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!locked, "R1 locked in reset", int'(locked), 0);
    chk(!sync_pulse, "R1 sync in reset", int'(sync_pulse), 0);
    chk(!fault_pulse, "R1 fault in reset", int'(fault_pulse), 0);
    chk({ts_cnt, bit_cnt} == 8'd0, "R1 counters in reset", int'({ts_cnt, bit_cnt}), 0);
    rst_n = 1'b1;

    for (int k = 0; k < KEND; k++) begin
      bit b;
      b = stream_bit(k);
      rx_bit = b;
      @(posedge clk);
      model_step(b);
      @(negedge clk);
      compare_model();
      if (k < 511 && fault_pulse) early_faults++;
      if (!locked && sync_pulse) sync_unlocked++;
      if (k == 510) chk(early_faults == 0, "R8 no fault before 512 unlocked cycles", early_faults, 0);
      if (k == 511) chk(fault_pulse && !locked, "R8 periodic fault after reset", int'(fault_pulse), 1);
      if (k == kidx(4, 7) - 1) chk(!locked, "R4 no lock before third word", int'(locked), 0);
      if (k == kidx(4, 7)) begin
        chk(locked, "R4 lock after word-service-word", int'(locked), 1);
        chk({ts_cnt, bit_cnt} == 8'd8, "R3 realigned position", int'({ts_cnt, bit_cnt}), 8);
      end
      if (k == kidx(5, 254)) begin
        chk(sync_pulse, "R5 sync before alignment frame", int'(sync_pulse), 1);
        chk(ts_cnt == 5'd31 && bit_cnt == 3'd7, "R2 last slot last bit", int'({ts_cnt, bit_cnt}), 255);
      end
      if (k == kidx(5, 255)) begin
        chk(!sync_pulse, "R5 sync lasts one cycle", int'(sync_pulse), 0);
        chk({ts_cnt, bit_cnt} == 8'd0, "R2 wrap to zero", int'({ts_cnt, bit_cnt}), 0);
      end
      if (k == kidx(6, 254)) chk(!sync_pulse, "R5 no sync before service frame", int'(sync_pulse), 0);
      if (k == kidx(10, 7)) chk(fault_pulse && locked, "R6 single error fault, lock kept", int'(fault_pulse), 1);
      if (k == kidx(16, 7) + 1) chk(!fault_pulse, "R6 fault one cycle", int'(fault_pulse), 0);
      if (k == kidx(24, 7)) chk(fault_pulse && locked, "R7 second error keeps lock", int'(locked), 1);
      if (k == kidx(26, 7)) chk(fault_pulse && !locked, "R7 third error drops lock with fault", int'(locked), 0);
      if (k == kidx(28, 7)) chk(fault_pulse && !locked, "R8 periodic fault after loss", int'(fault_pulse), 1);
      if (k == kidx(30, 7)) chk(fault_pulse && locked, "R4 relock coincides with R8 periodic fault", int'({fault_pulse, locked}), 3);
      if (k == kidx(30, 7) + 1) chk(!fault_pulse, "R8 coincident fault one cycle", int'(fault_pulse), 0);
      if (k == kidx(40, 7)) chk(fault_pulse && locked, "R7 good word cleared error run", int'(locked), 1);
    end
    chk(sync_unlocked == 0, "R8 sync suppressed while unlocked", sync_unlocked, 0);
    chk(locked, "R7 lock held at end", int'(locked), 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule